// File: doc/BRIEF.md
# Trace Buffer Write Pointer

This block keeps the write position of a circular trace buffer that lives in on-chip SRAM. Trace packets are two 32-bit words long. The packet source offers each packet on a valid/ready handshake. For every packet the block accepts, it drives two registered write beats to the SRAM write port. Both beats carry the packet's byte address, and a word-select picks the first or the second word. Each accepted packet moves the pointer one packet (8 bytes) forward.

The pointer only counts through a window of low-order bits. A mask input sets the width of that window, and the bits above it do not change. When the window rolls over from all ones to zero, a sticky wrap flag is set. A debug agent can use that flag to tell whether the older part of the buffer holds valid data.

Software reads and writes the position word through a plain register port. The block also turns the position into a system bus address, using a base value supplied on an input.

Back-pressure rules: `pkt_ready` is low only in the cycle when the first beat of a packet is shown. While `pkt_ready` is low, `pkt_valid` is ignored. The fastest rate is therefore one packet every two cycles. The SRAM port has no ready input and is assumed to take every beat.

Top module: `trace_wptr`

## Requirements
- R1: After reset, `pos_rd_data` reads 0, `mem_valid` is 0 and `pkt_ready` is 1.
- R2: A packet is accepted at a clock edge where `pkt_valid` and `pkt_ready` are both 1. After that edge `mem_valid`=1, `mem_word`=0 and `mem_addr` = the pre-accept pointer times 8. After the next edge `mem_valid`=1, `mem_word`=1 and `mem_addr` is unchanged. `pkt_ready` is 0 only while the first beat is shown.
- R3: Each accepted packet adds 1 to the pointer field, which is `pos_rd_data[AWIDTH-1:3]`, inside the window chosen by the mask.
- R4: The window is the low `mask` bits of the pointer field. When those bits are all ones, an accepted packet clears them, leaves the pointer bits above the window unchanged, and sets the wrap flag `pos_rd_data[2]` to 1.
- R5: The wrap flag is sticky. Once set, only a register write with bit 2 = 0 clears it.
- R6: A register write loads the pointer from `pos_wr_data[AWIDTH-1:3]` and the wrap flag from `pos_wr_data[2]`. Bits [1:0] and bits at or above AWIDTH are ignored and always read as 0.
- R7: When a register write and a packet accept fall on the same edge, the register write sets the pointer and the wrap flag. The packet is still written at the pre-write pointer.
- R8: A mask value of AWIDTH-3 or more counts over the whole pointer field. A mask of 0 leaves the pointer unchanged and sets the wrap flag on every accepted packet.
- R9: `sys_addr` = base + ((P + 2^AWIDTH − (base mod 2^AWIDTH)) mod 2^AWIDTH), where P is `pos_rd_data` with bits [2:0] cleared. The result wraps modulo 2^32.
- R10: A `pkt_valid` that arrives while `pkt_ready` is 0 has no effect on the pointer, the wrap flag or the beat sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet offered by the trace source |
| pkt_ready | output | 1 | Block can accept a packet |
| mask | input | MW | Width of the pointer's wrap window, in bits |
| base | input | 32 | System base address of the trace SRAM |
| pos_wr_en | input | 1 | Register write strobe |
| pos_wr_data | input | 32 | Register write data |
| pos_rd_data | output | 32 | Position word: pointer, wrap flag, zero bits |
| mem_valid | output | 1 | SRAM write beat valid |
| mem_word | output | 1 | 0 = first packet word, 1 = second |
| mem_addr | output | AWIDTH | SRAM byte address of the packet |
| sys_addr | output | 32 | System address of the next packet location |

## Verification
The bench drives the pointer to an all-ones window and checks the rollover. A design that wraps at the wrong width, carries into the upper bits, or misses the wrap flag would show a wrong position word or flag there. It sets the mask to 0 and to values above the field width. A wrong clamp would either freeze the pointer or let it run past the window. It also makes a register write and a packet accept collide on one edge, and it holds `pkt_valid` high while the first beat is shown. Those two cases catch a wrong priority and a second packet slipping in. Random bases near the address-width boundary check the modulo in the system-address formula.

// File: rtl/trace_wptr_pkg.sv
package trace_wptr_pkg;
  typedef enum logic [1:0] {
    BEAT_IDLE = 2'd0,
    BEAT_LO   = 2'd1,
    BEAT_HI   = 2'd2
  } beat_e;
endpackage

// File: rtl/trace_wptr_step.sv
// Next pointer value inside the mask-selected wrap window.
module trace_wptr_step #(
  parameter int PW = 9,
  parameter int MW = 4
) (
  input  logic [PW-1:0] ptr_i,
  input  logic [MW-1:0] mask_i,
  output logic [PW-1:0] ptr_next_o,
  output logic [PW-1:0] field_o,
  output logic          wrap_o
);
  logic [PW-1:0] field;
  logic [PW-1:0] inc;

  always_comb begin
    field = '0;
    for (int i = 0; i < PW; i++) begin
      if (i < int'(mask_i)) field[i] = 1'b1;
    end
  end

  assign inc        = ptr_i + 1'b1;
  assign ptr_next_o = (ptr_i & ~field) | (inc & field);
  assign wrap_o     = ((ptr_i & field) == field);
  assign field_o    = field;
endmodule

// File: rtl/trace_wptr_beat.sv
// Two-beat SRAM write sequencer, one packet at a time.
module trace_wptr_beat
  import trace_wptr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          mem_valid_o,
  output logic          mem_word_o,
  output logic [AW-1:0] mem_addr_o
);
  beat_e         state_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= BEAT_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        BEAT_LO: state_q <= BEAT_HI;
        default: begin
          if (accept_i) begin
            state_q <= BEAT_LO;
            addr_q  <= addr_i;
          end else begin
            state_q <= BEAT_IDLE;
          end
        end
      endcase
    end
  end

  assign busy_o      = (state_q == BEAT_LO);
  assign mem_valid_o = (state_q != BEAT_IDLE);
  assign mem_word_o  = (state_q == BEAT_HI);
  assign mem_addr_o  = addr_q;

  assert_beat_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_word_o) |=> (mem_valid_o && mem_word_o && $stable(mem_addr_o)));

  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept_i);
endmodule

// File: rtl/trace_wptr_sysaddr.sv
// Converts the buffer-relative position into a system bus address.
module trace_wptr_sysaddr #(
  parameter int AW = 12
) (
  input  logic [AW-1:0] pos_i,
  input  logic [31:0]   base_i,
  output logic [31:0]   sys_o
);
  localparam int HI = 32 - AW;
  logic [AW-1:0] p;
  logic [AW-1:0] off;

  assign p     = {pos_i[AW-1:3], 3'b000};
  assign off   = p - base_i[AW-1:0];
  assign sys_o = base_i + {{HI{1'b0}}, off};
endmodule

// File: rtl/trace_wptr.sv
module trace_wptr #(
  parameter  int AWIDTH = 12,
  localparam int PW     = AWIDTH - 3,
  localparam int MW     = $clog2(PW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [MW-1:0]     mask,
  input  logic [31:0]       base,
  input  logic              pos_wr_en,
  input  logic [31:0]       pos_wr_data,
  output logic [31:0]       pos_rd_data,
  output logic              mem_valid,
  output logic              mem_word,
  output logic [AWIDTH-1:0] mem_addr,
  output logic [31:0]       sys_addr
);
  localparam int ZW = 32 - AWIDTH;

  logic [PW-1:0] ptr_q;
  logic          wrap_q;
  logic [PW-1:0] ptr_next;
  logic [PW-1:0] field;
  logic          wrap_step;
  logic          busy;
  logic          accept;

  assign pkt_ready = !busy;
  assign accept    = pkt_valid && pkt_ready;

  trace_wptr_step #(.PW(PW), .MW(MW)) i_step (
    .ptr_i      (ptr_q),
    .mask_i     (mask),
    .ptr_next_o (ptr_next),
    .field_o    (field),
    .wrap_o     (wrap_step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else if (pos_wr_en) begin
      ptr_q  <= pos_wr_data[AWIDTH-1:3];
      wrap_q <= pos_wr_data[2];
    end else if (accept) begin
      ptr_q <= ptr_next;
      if (wrap_step) wrap_q <= 1'b1;
    end
  end

  assign pos_rd_data = {{ZW{1'b0}}, ptr_q, wrap_q, 2'b00};

  trace_wptr_beat #(.AW(AWIDTH)) i_beat (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .addr_i      ({ptr_q, 3'b000}),
    .busy_o      (busy),
    .mem_valid_o (mem_valid),
    .mem_word_o  (mem_word),
    .mem_addr_o  (mem_addr)
  );

  trace_wptr_sysaddr #(.AW(AWIDTH)) i_sys (
    .pos_i  (pos_rd_data[AWIDTH-1:0]),
    .base_i (base),
    .sys_o  (sys_addr)
  );

  assert_sw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_wr_en |=> (ptr_q == $past(pos_wr_data[AWIDTH-1:3]) && wrap_q == $past(pos_wr_data[2])));

  assert_wrap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !pos_wr_en) |=> wrap_q);

  assert_high_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pos_wr_en) |=> ((ptr_q & ~$past(field)) == ($past(ptr_q) & ~$past(field))));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !pos_wr_en) |=> $stable(ptr_q));
endmodule

// File: tb/test_trace_wptr.sv
module test_trace_wptr;
  localparam int AW = 12;
  localparam int PW = AW - 3;
  localparam int MW = $clog2(PW + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pkt_valid;
  logic          pkt_ready;
  logic [MW-1:0] mask;
  logic [31:0]   base;
  logic          pos_wr_en;
  logic [31:0]   pos_wr_data;
  logic [31:0]   pos_rd_data;
  logic          mem_valid;
  logic          mem_word;
  logic [AW-1:0] mem_addr;
  logic [31:0]   sys_addr;

  int checks = 0;
  int errors = 0;

  int unsigned m_ptr, m_wrap, m_state, m_addr;

  always #10 clk = ~clk;

  trace_wptr #(.AWIDTH(AW)) i_trace_wptr (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .mask(mask), .base(base), .pos_wr_en(pos_wr_en), .pos_wr_data(pos_wr_data),
    .pos_rd_data(pos_rd_data), .mem_valid(mem_valid), .mem_word(mem_word),
    .mem_addr(mem_addr), .sys_addr(sys_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int unsigned f_next(input int unsigned p, input int unsigned m, output bit w);
    int unsigned mm, lm;
    mm = (m > PW) ? PW : m;
    lm = (1 << mm) - 1;
    w  = ((p & lm) == lm);
    return ((p & ~lm) | ((p + 1) & lm)) & ((1 << PW) - 1);
  endfunction

  function automatic logic [31:0] f_sys(input logic [31:0] pos, input logic [31:0] b);
    longint unsigned p, sz, r;
    sz = 64'd1 << AW;
    p  = longint'(pos) & 64'hFFFF_FFF8;
    r  = (longint'(b) + ((p + (sz - (longint'(b) % sz))) % sz)) & 64'hFFFF_FFFF;
    return r[31:0];
  endfunction

  // One cycle: drive at the falling edge, model the rising edge, check at the next falling edge.
  task automatic cyc(input bit v, input bit wr, input logic [31:0] wd, input string ptag);
    bit acc, w;
    int unsigned np;
    string tag;
    pkt_valid   = v;
    pos_wr_en   = wr;
    pos_wr_data = wd;
    chk(v && m_state == 1 ? "R10" : "R2", {31'd0, pkt_ready}, {31'd0, m_state != 1});
    acc = v && (m_state != 1);
    tag = ptag;
    np = f_next(m_ptr, mask, w);
    if (acc) m_addr = m_ptr << 3;
    if (m_state == 1) m_state = 2;
    else m_state = acc ? 1 : 0;
    if (wr) begin
      m_ptr  = (wd >> 3) & ((1 << PW) - 1);
      m_wrap = wd[2];
      if (tag == "") tag = acc ? "R7" : "R6";
    end else if (acc) begin
      m_ptr = np;
      if (w) m_wrap = 1;
      if (tag == "") tag = (mask == 0) ? "R8" : (w ? "R4" : "R3");
    end
    if (tag == "") tag = v ? "R10" : "R5";
    @(posedge clk);
    @(negedge clk);
    chk(tag, pos_rd_data, (m_ptr << 3) | (m_wrap << 2));
    chk("R2", {31'd0, mem_valid}, {31'd0, m_state != 0});
    if (m_state != 0) begin
      chk("R2", {31'd0, mem_word}, {31'd0, m_state == 2});
      chk("R2", {20'd0, mem_addr}, m_addr);
    end
    chk("R9", sys_addr, f_sys(pos_rd_data, base));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; pkt_valid = 0; pos_wr_en = 0; pos_wr_data = 0;
    mask = PW[MW-1:0]; base = 32'h2000_0000;
    m_ptr = 0; m_wrap = 0; m_state = 0; m_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", pos_rd_data, 32'd0);
    chk("R1", {31'd0, mem_valid}, 32'd0);
    chk("R1", {31'd0, pkt_ready}, 32'd1);

    // R6: upper bits and bits [1:0] ignored; pointer all ones
    cyc(0, 1, 32'hFFFF_FFFB, "R6");
    chk("R6", pos_rd_data, 32'h0000_0FF8);
    // R4 full-width rollover, then valid held during busy (R10)
    cyc(1, 0, 0, "R4");
    chk("R4", pos_rd_data, 32'h0000_0004);
    cyc(1, 0, 0, "R10");
    cyc(1, 0, 0, "R3");
    cyc(0, 0, 0, "R5");
    chk("R5", {31'd0, pos_rd_data[2]}, 32'd1);
    cyc(0, 1, 32'h0000_0008, "R5");
    chk("R5", {31'd0, pos_rd_data[2]}, 32'd0);

    // R4 narrow window: mask 3, pointer 0x17 -> 0x10
    mask = 3;
    cyc(0, 1, 32'h0000_00B8, "R6");
    cyc(1, 0, 0, "R4");
    chk("R4", pos_rd_data, 32'h0000_0084);
    cyc(0, 0, 0, "R2");

    // R8: mask 0 holds pointer, sets wrap; mask above width clamps
    mask = 0;
    cyc(0, 1, 32'h0000_0050, "R6");
    cyc(1, 0, 0, "R8");
    chk("R8", pos_rd_data, 32'h0000_0054);
    cyc(0, 0, 0, "R2");
    mask = {MW{1'b1}};
    cyc(0, 1, 32'h0000_0FF8, "R6");
    cyc(1, 0, 0, "R8");
    chk("R8", pos_rd_data, 32'h0000_0004);
    cyc(0, 0, 0, "R2");

    // R7: write and accept together
    mask = PW[MW-1:0];
    cyc(0, 1, 32'h0000_0100, "R6");
    cyc(1, 1, 32'h0000_0400, "R7");
    chk("R7", pos_rd_data, 32'h0000_0400);
    chk("R7", {20'd0, mem_addr}, 32'h0000_0100);
    cyc(0, 0, 0, "R2");

    // R9 boundary bases
    base = 32'hFFFF_F000; cyc(0, 0, 0, "R9");
    base = 32'h1234_5FFF; cyc(0, 0, 0, "R9");
    base = 32'h0000_0408; cyc(0, 0, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) mask = MW'($urandom % (1 << MW));
      base = $urandom;
      cyc(($urandom % 3) != 0, ($urandom % 16) == 0, $urandom, "");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule